// File: doc/BRIEF.md
# GPIO Bank Register File with Bit-Masked Writes

This block holds the control registers of one GPIO bank and drives the pads of that bank. The bank has four ports of eight pins. Each port has three writable registers and one read-only register. The first writable register selects, per pin, whether the GPIO logic or an on-chip special function owns the pad. The second is the output enable and the third is the output value. The read-only register returns the pad levels after a two-flop synchroniser. Pin `p*8+b` of the flat pad vectors is bit `b` of port `p`, which matches the low five bits of a global pin number: the port sits in bits [4:3] and the bit in [2:0].

Software reaches the registers over a plain register bus: address, write data, a write strobe and combinational read data. Register offsets are 0x00 for owner select, 0x10 for output enable, 0x20 for output value and 0x30 for input, plus 4 times the port index. Every writable register also appears a second time at 0x800 above its normal offset. A write there treats data bits [15:8] as a per-bit enable for the value bits [7:0]. A single pin can therefore be changed in one bus write, with no read-modify-write and no race against other software that owns the neighbouring pins.

The safe way to turn a pin into an output takes two masked writes. The first sets the output value and the second sets the output enable, so the pad never drives a stale level.

Top module: `gpb_bank`

## Requirements
- R1: After reset, owner select, output enable and output value of every port read as 0. Every pad then takes its output and enable from `sf_out` and `sf_oe`.
- R2: A write to 0x00, 0x10 or 0x20 plus 4*port loads bits [7:0] of the write data into that port's register. Reading the same address returns the register in bits [7:0] and zero in bits [31:8].
- R3: A write to 0x800 plus a writable offset changes register bit i only where data bit 8+i is 1, and sets it to data bit i. Register bits whose enable bit is 0 keep their value.
- R4: Reading a masked alias (0x800 plus a writable offset) returns the current value of the underlying register.
- R5: Reading 0x30 plus 4*port returns, in bits [7:0], the port's pad inputs as they stood two clock edges earlier, with bits [31:8] zero. Writes to 0x30 plus 4*port change no register.
- R6: Where a pin's owner-select bit is 1, the pad output and pad enable of that pin come from the output value and output enable registers. Where the bit is 0, they come from `sf_out` and `sf_oe`.
- R7: A register write takes effect at the pads on the clock edge that captures it, and registers change only on such write edges. Setting the output value first and the output enable second gives a pad that shows the new value from the first cycle its enable is 1.
- R8: An address with bits [1:0] nonzero, with any of bits [10:6] or [31:12] set, or equal to 0x830 plus 4*port (no masked alias of the input register) reads as zero, and a write to it changes no register.
- R9: A write to one port leaves the registers of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sf_out | input | 32 | Special-function output value, one bit per pin |
| sf_oe | input | 32 | Special-function output enable, one bit per pin |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |

## Verification
On every cycle the assertions check that the registers hold without a write and across writes to other ports or to unmapped addresses. They also check the result of plain and masked writes on the following cycle, that the pads follow the special function right after reset, and that the input register lags the pads by exactly two edges. The bench scenarios cover what needs chosen patterns. These are the mixed ownership of pins within one port, zero-extension of read data, aliases reading back the same register, writes to the input register being dropped, and the ordered value-then-enable sequence seen at the pads.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
package gpb_pkg;
   // register kind lives in address bits [5:4]
   typedef enum logic [1:0] {
      RK_CFG = 2'd0,
      RK_OE  = 2'd1,
      RK_OUT = 2'd2,
      RK_IN  = 2'd3
   } reg_kind_e;

   localparam int KIND_LSB = 4;
   localparam int PSEL_LSB = 2;
   localparam int PSEL_W   = 2;
   localparam int MAP_BITS = 6'h3C;

   typedef struct packed {
      logic      hit;
      logic      masked;
      reg_kind_e kind;
      logic [PSEL_W-1:0] port;
   } dec_t;
endpackage

// File: rtl/gpb_decode.sv
`timescale 1ns/1ps
module gpb_decode
   import gpb_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int PORTS     = 4,
   parameter int MASK_BASE = 'h800
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam int MASK_BIT = $clog2(MASK_BASE);
   localparam logic [ADDR_W-1:0] LEGAL = ADDR_W'(MASK_BASE) | ADDR_W'(MAP_BITS);

   logic outside;
   logic port_ok;

   always_comb begin
      dec.masked = addr[MASK_BIT];
      dec.kind   = reg_kind_e'(addr[KIND_LSB +: 2]);
      dec.port   = addr[PSEL_LSB +: PSEL_W];
      outside    = (addr & ~LEGAL) != '0;
      port_ok    = 32'(dec.port) < PORTS;
      dec.hit    = !outside && port_ok && !(dec.masked && dec.kind == RK_IN);
   end
endmodule

// File: rtl/gpb_sync.sv
`timescale 1ns/1ps
module gpb_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int k = 0; k < STAGES; k++) st[k] <= '0;
            end else begin
               st[0] <= d;
               for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpb_port.sv
`timescale 1ns/1ps
module gpb_port
   import gpb_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic            masked,
   input  reg_kind_e       kind,
   input  logic [PINS-1:0] wval,
   input  logic [PINS-1:0] wmask,
   input  logic [PINS-1:0] sf_out,
   input  logic [PINS-1:0] sf_oe,
   output logic [PINS-1:0] cfg_q,
   output logic [PINS-1:0] oe_q,
   output logic [PINS-1:0] out_q,
   output logic [PINS-1:0] pad_out,
   output logic [PINS-1:0] pad_oe
);
   function automatic logic [PINS-1:0] f_next(input logic [PINS-1:0] old,
                                              input logic              msk_mode,
                                              input logic [PINS-1:0] val,
                                              input logic [PINS-1:0] en);
      return msk_mode ? ((old & ~en) | (val & en)) : val;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         oe_q  <= '0;
         out_q <= '0;
      end else if (wr_en) begin
         case (kind)
            RK_CFG:  cfg_q <= f_next(cfg_q, masked, wval, wmask);
            RK_OE:   oe_q  <= f_next(oe_q,  masked, wval, wmask);
            RK_OUT:  out_q <= f_next(out_q, masked, wval, wmask);
            default: ;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < PINS; i++) begin : g_pin
         assign pad_out[i] = cfg_q[i] ? out_q[i] : sf_out[i];
         assign pad_oe[i]  = cfg_q[i] ? oe_q[i]  : sf_oe[i];
      end
   endgenerate
endmodule

// File: rtl/gpb_bank.sv
`timescale 1ns/1ps
module gpb_bank
   import gpb_pkg::*;
#(
   parameter int PORTS       = 4,
   parameter int PINS        = 8,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int MASK_BASE   = 'h800,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_we,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [PORTS*PINS-1:0] sf_out,
   input  logic [PORTS*PINS-1:0] sf_oe,
   input  logic [PORTS*PINS-1:0] pad_in,
   output logic [PORTS*PINS-1:0] pad_out,
   output logic [PORTS*PINS-1:0] pad_oe
);
   localparam int NPIN = PORTS * PINS;

   generate
      if (PINS * 2 > DATA_W) begin : g_chk_width
         $error("gpb_bank: data bus too narrow for value and enable halves");
      end
      if (PINS > 8 || PORTS < 1 || PORTS > 4) begin : g_chk_shape
         $error("gpb_bank: port layout does not fit the 4-byte stride map");
      end
      if ((MASK_BASE & (MASK_BASE - 1)) != 0 || MASK_BASE < 'h40 ||
          $clog2(MASK_BASE) >= ADDR_W) begin : g_chk_alias
         $error("gpb_bank: alias base must be a power of two above the map");
      end
   endgenerate

   dec_t            dec;
   logic            wr_ok;
   logic [NPIN-1:0] cfg_all;
   logic [NPIN-1:0] oe_all;
   logic [NPIN-1:0] out_all;
   logic [NPIN-1:0] in_all;
   logic [PINS-1:0] rsel;

   gpb_decode #(
      .ADDR_W(ADDR_W), .PORTS(PORTS), .MASK_BASE(MASK_BASE)
   ) u_dec (
      .addr(bus_addr),
      .dec (dec)
   );

   assign wr_ok = bus_we && dec.hit && dec.kind != RK_IN;

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         gpb_port #(.PINS(PINS)) u_port (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_ok && 32'(dec.port) == p),
            .masked (dec.masked),
            .kind   (dec.kind),
            .wval   (bus_wdata[PINS-1:0]),
            .wmask  (bus_wdata[PINS +: PINS]),
            .sf_out (sf_out[p*PINS +: PINS]),
            .sf_oe  (sf_oe[p*PINS +: PINS]),
            .cfg_q  (cfg_all[p*PINS +: PINS]),
            .oe_q   (oe_all[p*PINS +: PINS]),
            .out_q  (out_all[p*PINS +: PINS]),
            .pad_out(pad_out[p*PINS +: PINS]),
            .pad_oe (pad_oe[p*PINS +: PINS])
         );
      end
   endgenerate

   gpb_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (pad_in),
      .q  (in_all)
   );

   always_comb begin
      rsel = '0;
      if (dec.hit) begin
         case (dec.kind)
            RK_CFG:  rsel = cfg_all[32'(dec.port)*PINS +: PINS];
            RK_OE:   rsel = oe_all[32'(dec.port)*PINS +: PINS];
            RK_OUT:  rsel = out_all[32'(dec.port)*PINS +: PINS];
            default: rsel = in_all[32'(dec.port)*PINS +: PINS];
         endcase
      end
      bus_rdata = {{(DATA_W-PINS){1'b0}}, rsel};
   end
endmodule

// File: rtl/gpb_bank_chk.sv
`timescale 1ns/1ps
module gpb_bank_chk #(
   parameter int PORTS       = 4,
   parameter int PINS        = 8,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int MASK_BASE   = 'h800,
   parameter int SYNC_STAGES = 2
) (
   input logic                  clk,
   input logic                  rst,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic                  bus_we,
   input logic [PORTS*PINS-1:0] sf_out,
   input logic [PORTS*PINS-1:0] sf_oe,
   input logic [PORTS*PINS-1:0] pad_in,
   input logic [PORTS*PINS-1:0] pad_out,
   input logic [PORTS*PINS-1:0] pad_oe,
   input logic [PORTS*PINS-1:0] cfg_all,
   input logic [PORTS*PINS-1:0] oe_all,
   input logic [PORTS*PINS-1:0] out_all,
   input logic [PORTS*PINS-1:0] in_all
);
   localparam logic [ADDR_W-1:0] LEGAL = ADDR_W'(MASK_BASE) | ADDR_W'(6'h3C);
   localparam logic [ADDR_W-1:0] OE_A  = ADDR_W'('h10);
   localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'('h20);
   localparam logic [ADDR_W-1:0] MB    = ADDR_W'(MASK_BASE);

   logic [1:0] cyc;
   always_ff @(posedge clk) begin
      if (rst) cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   assert_reset_pads_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pad_out == sf_out && pad_oe == sf_oe));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !bus_we |=> ($stable(cfg_all) && $stable(oe_all) && $stable(out_all)));

   assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
      (bus_we && ((bus_addr & ~LEGAL) != '0 || bus_addr[1:0] != 2'b00))
      |=> ($stable(cfg_all) && $stable(oe_all) && $stable(out_all)));

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_p
         assert_other_port_R9: assert property (@(posedge clk) disable iff (rst)
            (bus_we && 32'(bus_addr[3:2]) != p) |=>
            ($stable(cfg_all[p*PINS +: PINS]) && $stable(oe_all[p*PINS +: PINS]) &&
             $stable(out_all[p*PINS +: PINS])));

         assert_plain_out_R2: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == OUT_A + ADDR_W'(4*p)) |=>
            out_all[p*PINS +: PINS] == $past(bus_wdata[PINS-1:0]));

         assert_masked_out_R3: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == MB + OUT_A + ADDR_W'(4*p)) |=>
            out_all[p*PINS +: PINS] ==
               (($past(out_all[p*PINS +: PINS]) & ~$past(bus_wdata[PINS +: PINS])) |
                ($past(bus_wdata[PINS-1:0]) & $past(bus_wdata[PINS +: PINS]))));

         assert_masked_oe_R3: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == MB + OE_A + ADDR_W'(4*p)) |=>
            oe_all[p*PINS +: PINS] ==
               (($past(oe_all[p*PINS +: PINS]) & ~$past(bus_wdata[PINS +: PINS])) |
                ($past(bus_wdata[PINS-1:0]) & $past(bus_wdata[PINS +: PINS]))));
      end
      if (SYNC_STAGES == 2) begin : g_sync
         assert_input_lag_R5: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 2'd2) |-> in_all == $past(pad_in, 2));
      end
   endgenerate
endmodule

bind gpb_bank gpb_bank_chk #(
   .PORTS(PORTS), .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .MASK_BASE(MASK_BASE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_we(bus_we), .sf_out(sf_out), .sf_oe(sf_oe), .pad_in(pad_in),
   .pad_out(pad_out), .pad_oe(pad_oe), .cfg_all(cfg_all), .oe_all(oe_all),
   .out_all(out_all), .in_all(in_all)
);

// File: tb/sim_gpb_bank.sv
`timescale 1ns/1ps
module sim_gpb_bank;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] sf_out = 32'h1234_5678;
   logic [31:0] sf_oe  = 32'h0F0F_0F0F;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] m_cfg [4];
   logic [7:0] m_oe  [4];
   logic [7:0] m_out [4];

   always #4 clk = ~clk;

   gpb_bank u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .sf_out(sf_out), .sf_oe(sf_oe),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%08h exp=%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] flat(input logic [7:0] v [4]);
      return {v[3], v[2], v[1], v[0]};
   endfunction

   task automatic check_regs(input string req);
      logic [31:0] d;
      for (int p = 0; p < 4; p++) begin
         bus_read(12'(4*p), d);          chk(req, d, {24'h0, m_cfg[p]});
         bus_read(12'('h10 + 4*p), d);   chk(req, d, {24'h0, m_oe[p]});
         bus_read(12'('h20 + 4*p), d);   chk(req, d, {24'h0, m_out[p]});
      end
   endtask

   task automatic check_pads(input string req);
      logic [31:0] c;
      @(negedge clk);
      c = flat(m_cfg);
      chk(req, pad_out, (c & flat(m_out)) | (~c & sf_out));
      chk(req, pad_oe,  (c & flat(m_oe))  | (~c & sf_oe));
   endtask

   function automatic logic [7:0] mrg(input logic [7:0] old, input logic [15:0] d);
      return (old & ~d[15:8]) | (d[7:0] & d[15:8]);
   endfunction

   task automatic t_reset;
      check_regs("R1");
      @(negedge clk);
      chk("R1 pad_out", pad_out, sf_out);
      chk("R1 pad_oe", pad_oe, sf_oe);
   endtask

   task automatic t_plain;
      logic [31:0] d;
      bus_write(12'h004, 32'hDEAD_BEA5); m_cfg[1] = 8'hA5;
      bus_write(12'h014, 32'hFFFF_FF3C); m_oe[1]  = 8'h3C;
      bus_write(12'h024, 32'h0000_11FF); m_out[1] = 8'hFF;
      bus_read(12'h004, d);
      chk("R2 upper bits zero", d, 32'h0000_00A5);
      check_regs("R2 R9");
   endtask

   task automatic t_masked;
      logic [31:0] d;
      bus_write(12'h824, 32'h0000_0F50); m_out[1] = mrg(m_out[1], 16'h0F50);
      bus_read(12'h024, d);  chk("R3 masked out", d, 32'h0000_00F0);
      bus_read(12'h824, d);  chk("R4 alias read out", d, 32'h0000_00F0);
      bus_write(12'h814, 32'h0000_00FF);
      bus_read(12'h014, d);  chk("R3 zero enable keeps", d, {24'h0, m_oe[1]});
      bus_read(12'h814, d);  chk("R4 alias read oe", d, {24'h0, m_oe[1]});
      bus_write(12'h804, 32'h0000_8100); m_cfg[1] = mrg(m_cfg[1], 16'h8100);
      bus_read(12'h804, d);  chk("R4 alias read cfg", d, {24'h0, m_cfg[1]});
      check_regs("R3 R9");
   endtask

   task automatic t_owner;
      sf_out = 32'hC3C3_5A5A;
      sf_oe  = 32'h9696_F00F;
      check_pads("R6 mixed owner");
      bus_write(12'h000, 32'h0000_00F0); m_cfg[0] = 8'hF0;
      bus_write(12'h010, 32'h0000_0033); m_oe[0]  = 8'h33;
      check_pads("R6 second port");
   endtask

   task automatic t_sequence;
      // port 2 pin 3 becomes a GPIO output: value first, enable second
      bus_write(12'h808, 32'h0000_0800); m_cfg[2] = 8'h00 | 8'h00;
      bus_write(12'h808, 32'h0000_0808); m_cfg[2] = 8'h08;
      @(negedge clk);
      chk("R7 owner taken, enable off", {31'h0, pad_oe[19]}, 32'h0);
      @(negedge clk);
      bus_addr = 12'h828; bus_wdata = 32'h0000_0808; bus_we = 1'b1;
      #1 chk("R7 before edge", {31'h0, pad_out[19]}, 32'h0);
      @(negedge clk);
      bus_we = 1'b0; m_out[2] = 8'h08;
      chk("R7 value after edge", {31'h0, pad_out[19]}, 32'h1);
      chk("R7 enable still off", {31'h0, pad_oe[19]}, 32'h0);
      bus_write(12'h818, 32'h0000_0808); m_oe[2] = 8'h08;
      chk("R7 enable with value", {30'h0, pad_oe[19], pad_out[19]}, 32'h3);
      check_pads("R7 R6");
   endtask

   task automatic t_input;
      logic [31:0] d;
      @(negedge clk);
      pad_in = 32'hA1B2_C3D4;
      bus_addr = 12'h034;
      @(negedge clk);
      chk("R5 one edge not yet", bus_rdata, 32'h0);
      @(negedge clk);
      chk("R5 two edges", bus_rdata, 32'h0000_00C3);
      bus_read(12'h03C, d);  chk("R5 port3 input", d, 32'h0000_00A1);
      bus_write(12'h030, 32'hFFFF_FFFF);
      bus_read(12'h030, d);  chk("R5 write ignored", d, 32'h0000_00D4);
      check_regs("R5");
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      bus_write(12'h005, 32'h0000_FFFF);
      bus_write(12'h044, 32'h0000_FFFF);
      bus_write(12'h420, 32'h0000_FFFF);
      bus_write(12'h834, 32'h0000_FFFF);
      bus_read(12'h006, d);  chk("R8 misaligned read", d, 32'h0);
      bus_read(12'h060, d);  chk("R8 hole read", d, 32'h0);
      bus_read(12'h830, d);  chk("R8 no input alias", d, 32'h0);
      check_regs("R8");
   endtask

   initial begin : watchdog
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int p = 0; p < 4; p++) begin
         m_cfg[p] = '0; m_oe[p] = '0; m_out[p] = '0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_plain();
      t_masked();
      t_owner();
      t_sequence();
      t_input();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule